// File: doc/BRIEF.md
# Periodic Rate Generator

This block produces two timing outputs for a real-time clock. One is a square-wave level. The other is a sticky periodic flag. Both come from a single divider that advances on a one-cycle enable pulsing at 32.768 kHz. A 4-bit rate select chooses which divider bit drives both outputs. Code zero turns both outputs off.

The codes do not follow a single monotonic ladder. Codes 3 through 15 step from the fastest rate down to the slowest. Codes 1 and 2 reuse the rates of codes 8 and 9. For every code, the square-wave frequency is the reciprocal of the flag period.

Software reads the flag and clears it with a one-cycle strobe. A separate enable gates the flag onto an interrupt request output. Every port is a plain control or status pin. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_periodic_rate`

## Requirements
- R1: While rate_sel is 0, pf_flag never sets, sq_out stays low and the divider is held at zero.
- R2: Code 1 gives a flag period of 128 ticks (256 Hz on sq_out). Code 2 gives 256 ticks (128 Hz). These are the same rates as codes 8 and 9.
- R3: Codes 3, 4, 5, 6 and 7 give flag periods of 4, 8, 16, 32 and 64 ticks. This is 8192 Hz down to 512 Hz on sq_out.
- R4: Codes 8 to 15 give flag periods of 128 ticks, doubling with each code up to 16384 ticks. This is 256 Hz down to 2 Hz.
- R5: sq_out is high for exactly half of the selected flag period, so its frequency is the reciprocal of that period.
- R6: pf_flag sets on each rising edge of the selected divider bit. It stays set until pf_clr is high at a clock edge, and it reads low after that edge.
- R7: When a new rising edge and pf_clr fall on the same clock edge, pf_flag ends up set.
- R8: A change of rate_sel restarts the divider from zero at the next clock edge, and sq_out is low after that edge. With a tick on every cycle, the first flag set and the first sq_out rise come half the new period plus one cycle after that edge.
- R9: While sq_en is low, sq_out is low from the next edge on, and pf_flag keeps setting at the selected rate.
- R10: pi_irq equals pf_flag AND pi_en, combinationally.
- R11: The divider advances only on cycles with tick_32k high. With ticks spaced N cycles apart, every period stretches by N.
- R12: After reset, pf_flag, sq_out and pi_irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz that advances the divider |
| rate_sel | input | 4 | Rate select code (0 = off) |
| sq_en | input | 1 | Square-wave output enable |
| pi_en | input | 1 | Gates pf_flag onto pi_irq |
| pf_clr | input | 1 | Read-to-clear strobe for pf_flag |
| sq_out | output | 1 | Square-wave level, 50% duty |
| pf_flag | output | 1 | Sticky periodic flag |
| pi_irq | output | 1 | Interrupt request, pf_flag gated by pi_en |

## Verification
- A new rate_sel takes effect at the first clock edge after it is driven.
- The divider bit rises one edge after the tick that moves it. pf_flag and sq_out follow one edge after that. So with a tick on every cycle, the first flag comes 2^b + 1 edges after the select edge, where b is the selected divider bit.
- pf_clr acts at the next edge. pi_irq follows pf_flag in the same cycle.
- The bench samples 1 ns after each rising edge and counts edges between flag rises and between sq_out edges. The scoreboard pops the interval it expects only when such an event appears, so each check is tied to the edge on which the result is due.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  // Divider width: bit (DIV_W-1) toggles every 2^(DIV_W-1) ticks, which gives the slowest rate.
  localparam int unsigned RATE_DIV_W = 14;
  localparam int unsigned RATE_SEL_W = 4;

  // The fast ladder starts at this code and uses this divider bit.
  localparam int unsigned FAST_CODE0 = 3;
  localparam int unsigned FAST_BIT0  = 1;

  // Codes below FAST_CODE0 (other than 0) reuse a slow-ladder bit.
  localparam int unsigned ALIAS_SHIFT = 5;

  // Returns the divider bit that drives both outputs for a select code.
  // Code 0 returns 0, which callers treat as "off".
  function automatic int unsigned code_to_bit(input int unsigned code);
    if (code == 0)
      return 0;
    else if (code < FAST_CODE0)
      return code + ALIAS_SHIFT;
    else
      return code - FAST_CODE0 + FAST_BIT0;
  endfunction

endpackage

// File: rtl/rtc_div_counter.sv
module rtc_div_counter #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [DIV_W-1:0] count
);

  localparam logic [DIV_W-1:0] CNT_ZERO = '0;
  localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= CNT_ZERO;
    else if (clear)
      count <= CNT_ZERO;
    else if (step)
      count <= count + CNT_ONE;
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clear |=> $stable(count)); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear |=> count == $past(count) + CNT_ONE); // R11

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == CNT_ZERO); // R8

endmodule

// File: rtl/rtc_tap_select.sv
module rtc_tap_select #(
  parameter int unsigned DIV_W = 14,
  parameter int unsigned SEL_W = 4
) (
  input  logic [DIV_W-1:1] ladder,
  input  logic [SEL_W-1:0] sel,
  output logic             tap,
  output logic             live
);

  localparam int unsigned NCODE = 1 << SEL_W;

  logic [NCODE-1:0] tap_vec;
  logic [NCODE-1:0] live_vec;

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    localparam int unsigned BITN = rtc_rate_pkg::code_to_bit(c);
    if (c == 0 || BITN < 1 || BITN >= DIV_W) begin : g_off
      assign tap_vec[c]  = 1'b0;
      assign live_vec[c] = 1'b0;
    end else begin : g_on
      assign tap_vec[c]  = ladder[BITN];
      assign live_vec[c] = 1'b1;
    end
  end

  assign tap  = tap_vec[sel];
  assign live = live_vec[sel];

endmodule

// File: rtl/rtc_pf_flag.sv
module rtc_pf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic live,
  input  logic restart,
  input  logic clr,
  output logic flag
);

  logic tap_d;
  logic rise;

  // A rising edge of the selected bit counts only while a rate is live and
  // the select is not changing in this cycle.
  assign rise = live & tap & ~tap_d & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      tap_d <= live & tap & ~restart;
      if (rise)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !rise |=> !flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rise && !clr |=> $stable(flag)); // R6

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !live && !flag |=> !flag); // R1

endmodule

// File: rtl/rtc_periodic_rate.sv
module rtc_periodic_rate
  import rtc_rate_pkg::*;
#(
  parameter int unsigned DIV_W = RATE_DIV_W,
  parameter int unsigned SEL_W = RATE_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_32k,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             sq_en,
  input  logic             pi_en,
  input  logic             pf_clr,
  output logic             sq_out,
  output logic             pf_flag,
  output logic             pi_irq
);

  logic [SEL_W-1:0] sel_q;
  logic             restart;
  logic [DIV_W-1:0] count;
  logic             tap;
  logic             live;
  logic             sq_q;

  // Registered select. A mismatch marks the cycle in which the code changes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else
      sel_q <= rate_sel;
  end

  assign restart = (rate_sel != sel_q);

  rtc_div_counter #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (tick_32k),
    .clear (restart | ~live),
    .count (count)
  );

  rtc_tap_select #(
    .DIV_W (DIV_W),
    .SEL_W (SEL_W)
  ) u_tap (
    .ladder (count[DIV_W-1:1]),
    .sel    (sel_q),
    .tap    (tap),
    .live   (live)
  );

  rtc_pf_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tap     (tap),
    .live    (live),
    .restart (restart),
    .clr     (pf_clr),
    .flag    (pf_flag)
  );

  // Square wave: the selected bit, delayed one cycle to line up with the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sq_q <= 1'b0;
    else
      sq_q <= sq_en & live & tap & ~restart;
  end

  assign sq_out = sq_q;
  assign pi_irq = pf_flag & pi_en;

  AST_SQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |=> !sq_out); // R9

  AST_SQ_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sq_out); // R8

  AST_SQ_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !sq_out); // R1

endmodule

// File: tb/rtc_periodic_rate_tb.sv
`timescale 1ns/1ps
module rtc_periodic_rate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       sq_en = 1'b1;
  logic       pi_en = 1'b1;
  logic       drv_clr = 1'b0;
  logic       mon_clr = 1'b0;
  logic       pf_clr;
  logic       sq_out, pf_flag, pi_irq;

  assign pf_clr = drv_clr | mon_clr;

  always #2.5 clk = ~clk;

  rtc_periodic_rate u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_32k (tick),
    .rate_sel (rate_sel),
    .sq_en    (sq_en),
    .pi_en    (pi_en),
    .pf_clr   (pf_clr),
    .sq_out   (sq_out),
    .pf_flag  (pf_flag),
    .pi_irq   (pi_irq)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    tick_gap = 1;
  bit    mon_en = 0;
  int    epoch = 0;
  bit    done = 0;
  int    pf_q[$];
  string pf_tag_q[$];
  int    sq_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Square-wave frequency in Hz for each code, per R2, R3 and R4.
  function automatic int freq_of(input int code);
    case (code)
      1: return 256;
      2: return 128;
      3, 4, 5, 6, 7: return 8192 >> (code - 3);
      default: return 256 >> (code - 8);
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code < 3) return "R2";
    if (code < 8) return "R3";
    return "R4";
  endfunction

  // Tick source: one tick every tick_gap cycles.
  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (tick_gap <= 1) tick = 1'b1;
      else begin
        tick = (ph == 0);
        ph = (ph + 1) % tick_gap;
      end
    end
  end

  // Monitor and scoreboard.
  initial begin : monitor
    int seen_epoch, last_pf, sq_rise;
    bit pf_prev, sq_prev;
    seen_epoch = 0; last_pf = 0; sq_rise = -1; pf_prev = 0; sq_prev = 0;
    forever begin
      @(posedge clk);
      #1;
      mon_clr = 1'b0;
      if (!mon_en) begin
        pf_prev = pf_flag; sq_prev = sq_out; seen_epoch = epoch;
        continue;
      end
      if (epoch != seen_epoch) begin
        seen_epoch = epoch;
        last_pf = cyc;
        sq_rise = -1;
        if (pf_flag) mon_clr = 1'b1;
        pf_prev = pf_flag;
        sq_prev = sq_out;
        continue;
      end
      if (pf_flag && !pf_prev) begin
        if (pf_q.size() > 0) begin
          int e;
          string t;
          e = pf_q.pop_front();
          t = pf_tag_q.pop_front();
          if (e >= 0) check(t, cyc - last_pf, e, "flag interval in cycles");
        end
        last_pf = cyc;
        mon_clr = 1'b1;
      end
      if (sq_out && !sq_prev) sq_rise = cyc;
      if (!sq_out && sq_prev && sq_rise >= 0 && sq_q.size() > 0)
        check("R5", cyc - sq_rise, sq_q.pop_front(), "sq_out high width");
      pf_prev = pf_flag;
      sq_prev = sq_out;
    end
  end

  task automatic wait_drained();
    while (pf_q.size() != 0 || sq_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : driver
    int half, cstart, hi_cnt, pf_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", pf_flag, 0, "pf_flag in reset");
    check("R12", sq_out, 0, "sq_out in reset");
    check("R12", pi_irq, 0, "pi_irq in reset");
    rst_n = 1'b1;

    // R1: code 0 keeps everything quiet.
    hi_cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (pf_flag || sq_out || pi_irq) hi_cnt++;
    end
    check("R1", hi_cnt, 0, "cycles with activity at code 0");

    // R2, R3, R4, R5, R8: sweep every code with a tick on every cycle.
    for (int code = 1; code < 16; code++) begin
      @(negedge clk);
      half = 16384 / freq_of(code);
      pf_q.push_back(half + 1);  pf_tag_q.push_back("R8");
      pf_q.push_back(2 * half);  pf_tag_q.push_back(tag_of(code));
      pf_q.push_back(2 * half);  pf_tag_q.push_back(tag_of(code));
      sq_q.push_back(half);
      sq_q.push_back(half);
      rate_sel = 4'(code);
      epoch++;
      mon_en = 1'b1;
      wait_drained();
    end

    // R11: one tick every third cycle, code 4 (8 ticks).
    @(negedge clk);
    tick_gap = 3;
    pf_q.push_back(-1); pf_tag_q.push_back("R11");
    pf_q.push_back(24); pf_tag_q.push_back("R11");
    pf_q.push_back(24); pf_tag_q.push_back("R11");
    sq_q.push_back(12);
    sq_q.push_back(12);
    rate_sel = 4'd4;
    epoch++;
    wait_drained();
    mon_en = 1'b0;
    @(negedge clk);
    tick_gap = 1;
    repeat (4) @(posedge clk);

    // R7 / R6: clear held high; set at edge C+7 wins, clear acts at C+8.
    @(negedge clk);
    rate_sel = 4'd3;
    drv_clr = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check("R7", pf_flag, 1, "flag after set and clear on the same edge");
    @(posedge clk); #1;
    check("R6", pf_flag, 0, "flag one edge after clear");
    @(negedge clk);
    drv_clr = 1'b0;
    repeat (8) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
    check("R6", pf_flag, 1, "flag stays set without clear");

    // R10: irq gating.
    @(negedge clk);
    pi_en = 1'b1; #1;
    check("R10", pi_irq, 1, "irq with flag set and enable on");
    pi_en = 1'b0; #1;
    check("R10", pi_irq, 0, "irq with enable off");
    pi_en = 1'b1;
    rate_sel = 4'd0;
    @(negedge clk);
    drv_clr = 1'b1;
    @(negedge clk);
    drv_clr = 1'b0; #1;
    check("R6", pf_flag, 0, "flag after clear at code 0");
    check("R10", pi_irq, 0, "irq with flag clear");

    // R9: square wave muted, flag still running at code 5.
    @(negedge clk);
    sq_en = 1'b0;
    rate_sel = 4'd5;
    hi_cnt = 0; pf_cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (sq_out) hi_cnt++;
      if (pf_flag) pf_cnt++;
    end
    check("R9", hi_cnt, 0, "sq_out high cycles while disabled");
    check("R9", int'(pf_cnt > 0), 1, "flag set while square wave disabled");
    @(negedge clk);
    sq_en = 1'b1;
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (sq_out) hi_cnt++;
    end
    check("R9", int'(hi_cnt > 0), 1, "sq_out toggles after re-enable");

    // R8: change from code 5 to code 6 while sq_out is high.
    do begin @(posedge clk); #1; end while (!sq_out);
    @(negedge clk);
    rate_sel = 4'd6;
    @(posedge clk); #1;
    cstart = cyc;
    check("R8", sq_out, 0, "sq_out on the select-change edge");
    do begin @(posedge clk); #1; end while (!sq_out);
    check("R8", cyc - cstart, 17, "edges from select change to first sq_out rise");

    done = 1'b1;
    finish_run();
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule